// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI slave that lives inside a larger chip and takes control words from a host microcontroller. Each transfer is one 16-bit word. The upper four bits select a command and the lower twelve bits carry a data value. A valid word stores its data in the register that belongs to its command code. It also raises a one-cycle write strobe for that code, so downstream logic knows the value has just changed.

One command code is reserved for the operating-mode register. For that code only the low eight data bits are kept. The host runs SPI mode 0: the clock idles low, bits are captured on the rising SCLK edge, and MOSI changes on the falling edge. Bits arrive most significant first. The host deasserts chip select after every word.

SCLK, MOSI and chip select are treated as asynchronous inputs. Each is passed through a two-flop synchroniser into the system clock domain, and edges are detected there. For this reason the system clock must run at least four times faster than SCLK. A word is accepted only if its chip-select window contains exactly sixteen rising SCLK edges. Any other count is dropped without effect.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset every command register reads zero, the mode output is zero and no write strobe is active.
- R2: A word of exactly 16 bits is taken MSB first. Bits 15..12 are the command code `c` and bits 11..0 are the data. Accepting the word writes the data to `regs_o[c*12 +: 12]`.
- R3: MOSI is captured only on rising SCLK edges while chip select is low. A pattern that changes on every falling edge is therefore received unchanged.
- R4: Each accepted word pulses `wr_stb_o[c]` high for exactly one system clock cycle. At most one strobe bit is high at any time.
- R5: Command code 1 is the mode register. It stores only data bits 7..0, so `mode_o` equals those bits and bits 11..8 of that register entry read zero.
- R6: A chip-select window with fewer than 16 rising SCLK edges causes no register write and no strobe.
- R7: A chip-select window with more than 16 rising SCLK edges causes no register write and no strobe.
- R8: SCLK edges that occur while chip select is high are ignored. They do not count towards the next word.
- R9: Registers and strobe change at the third system clock edge after the first edge that samples chip select high at the end of an accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | SPI serial clock from the host, idle low |
| mosi_i | input | 1 | SPI serial data from the host |
| cs_n_i | input | 1 | SPI chip select, active low |
| regs_o | output | 192 | All sixteen 12-bit command registers, code `c` at bits `c*12 +: 12` |
| wr_stb_o | output | 16 | One-cycle write strobe per command code |
| mode_o | output | 8 | Contents of the mode register |

## Verification
The bench tries several kinds of words:
- Words with distinct command codes and data values. These show that the command and data fields are split at the right bit and that the word is assembled MSB first.
- An alternating-bit word driven with MOSI changing on every falling edge. A receiver that captured on the wrong SCLK edge would return a different value.
- Windows of 15 and 17 rising SCLK edges. These separate exact-length acceptance from a receiver that accepts any word of at least 16 bits, or one that keeps only the last 16 bits.
- Idle SCLK toggling before a word. This shows whether the bit counter is held while chip select is high.

A behavioural model of the synchroniser delay is compared with the outputs on every cycle. This pins down the write latency.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CMD_W_DEF  = 4;
  localparam int DATA_W_DEF = 12;
  localparam int MODE_W_DEF = 8;

  // Sampled SPI pin triple as carried through the synchroniser
  typedef struct packed {
    logic sclk;
    logic mosi;
    logic cs_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sclk: 1'b0, mosi: 1'b0, cs_n: 1'b1};
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync
  import spi_cmd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t pins_i,
  output spi_pins_t cur_o,
  output spi_pins_t prev_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  spi_pins_t stg_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= PINS_IDLE;
    end else begin
      stg_q[0] <= pins_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  spi_pins_t          cur_i,
  input  spi_pins_t          prev_i,
  output logic               vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic               vld_q, vld_d;
  logic [FRAME_W-1:0] frame_q;
  logic               sclk_rise, cs_rise, shift_en;

  always_comb begin
    sclk_rise = cur_i.sclk & ~prev_i.sclk;
    cs_rise   = cur_i.cs_n & ~prev_i.cs_n;
    shift_en  = sclk_rise & ~cur_i.cs_n;

    // Counter is held at zero while deselected; saturates one past a full frame
    cnt_d = cnt_q;
    if (cur_i.cs_n)
      cnt_d = '0;
    else if (shift_en && cnt_q != CNT_W'(CNT_MAX))
      cnt_d = cnt_q + 1'b1;

    shift_d = shift_en ? {shift_q[FRAME_W-2:0], cur_i.mosi} : shift_q;
    vld_d   = cs_rise && (cnt_q == CNT_W'(FRAME_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame_q <= '0;
    else if (cs_rise)
      frame_q <= shift_q;
  end

  assign vld_o   = vld_q;
  assign frame_o = frame_q;

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs #(
  parameter int CMD_W    = 4,
  parameter int DATA_W   = 12,
  parameter int MODE_CMD = 1,
  parameter int MODE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vld_i,
  input  logic [CMD_W+DATA_W-1:0]    frame_i,
  output logic [(1<<CMD_W)*DATA_W-1:0] regs_o,
  output logic [(1<<CMD_W)-1:0]      stb_o
);
  localparam int NUM_CMD = 1 << CMD_W;

  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data;
  logic [NUM_CMD-1:0] wr_en;
  logic [NUM_CMD-1:0] stb_q;
  logic [NUM_CMD*DATA_W-1:0] regs_q;

  assign cmd  = frame_i[DATA_W +: CMD_W];
  assign data = frame_i[DATA_W-1:0];

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    logic [DATA_W-1:0] wdata;
    assign wr_en[g] = vld_i && (cmd == CMD_W'(g));

    if (g == MODE_CMD) begin : g_mode
      assign wdata = {{(DATA_W-MODE_W){1'b0}}, data[MODE_W-1:0]};
    end else begin : g_plain
      assign wdata = data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en[g])
        regs_q[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= wr_en;
  end

  assign regs_o = regs_q;
  assign stb_o  = stb_q;

  // R4
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  // R6
  hold_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(regs_q));

  // R5
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && cmd == CMD_W'(MODE_CMD)) |=>
      regs_q[MODE_CMD*DATA_W +: DATA_W] == {{(DATA_W-MODE_W){1'b0}}, $past(data[MODE_W-1:0])});
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int CMD_W    = CMD_W_DEF,
  parameter int DATA_W   = DATA_W_DEF,
  parameter int MODE_W   = MODE_W_DEF,
  parameter int MODE_CMD = 1,
  parameter int SYNC_N   = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sclk_i,
  input  logic                                mosi_i,
  input  logic                                cs_n_i,
  output logic [(1<<CMD_W)*DATA_W-1:0]        regs_o,
  output logic [(1<<CMD_W)-1:0]               wr_stb_o,
  output logic [MODE_W-1:0]                   mode_o
);
  localparam int FRAME_W = CMD_W + DATA_W;

  logic rst_meta_q, rst_sync_q;
  spi_pins_t pins, cur, prev;
  logic vld;
  logic [FRAME_W-1:0] frame;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pins = '{sclk: sclk_i, mosi: mosi_i, cs_n: cs_n_i};

  spi_cmd_sync #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .pins_i (pins),
    .cur_o  (cur),
    .prev_o (prev)
  );

  spi_cmd_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cur_i   (cur),
    .prev_i  (prev),
    .vld_o   (vld),
    .frame_o (frame)
  );

  spi_cmd_regs #(
    .CMD_W    (CMD_W),
    .DATA_W   (DATA_W),
    .MODE_CMD (MODE_CMD),
    .MODE_W   (MODE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .vld_i   (vld),
    .frame_i (frame),
    .regs_o  (regs_o),
    .stb_o   (wr_stb_o)
  );

  assign mode_o = regs_o[MODE_CMD*DATA_W +: MODE_W];
endmodule

// File: tb/spi_cmd_rx_bench.sv
module spi_cmd_rx_bench;
  localparam int NC = 16;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [NC*DW-1:0] regs_o;
  logic [NC-1:0]    wr_stb_o;
  logic [7:0]       mode_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  spi_cmd_rx u_spi_cmd_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
    .regs_o(regs_o), .wr_stb_o(wr_stb_o), .mode_o(mode_o)
  );

  // Behavioural reference: pin history, edge count, pending write
  logic [11:0] m_reg [NC];
  logic [NC-1:0] m_stb;
  int  m_cnt;
  logic [15:0] m_shift, m_word;
  bit  m_pend, m_word_pend;
  logic h1_cs, h2_cs, h3_cs, h1_sc, h2_sc, h3_sc, h1_mo, h2_mo;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) m_reg[c] = '0;
      m_stb = '0; m_cnt = 0; m_shift = '0; m_pend = 0; m_word_pend = 0; m_word = '0;
      h1_cs = 1; h2_cs = 1; h3_cs = 1; h1_sc = 0; h2_sc = 0; h3_sc = 0;
      h1_mo = 0; h2_mo = 0;
    end else begin
      m_stb = '0;
      if (m_pend) begin
        m_pend = 0;
        if (m_word[15:12] == 4'd1) m_reg[1] = {4'h0, m_word[7:0]};
        else m_reg[m_word[15:12]] = m_word[11:0];
        m_stb[m_word[15:12]] = 1'b1;
      end
      if (h2_cs) begin
        if (!h3_cs && m_cnt == 16) begin
          m_pend = 1; m_word = m_shift;
        end
        m_cnt = 0;
      end else if (h2_sc && !h3_sc) begin
        m_shift = {m_shift[14:0], h2_mo};
        if (m_cnt < 17) m_cnt++;
      end
      h3_cs = h2_cs; h2_cs = h1_cs; h1_cs = cs_n;
      h3_sc = h2_sc; h2_sc = h1_sc; h1_sc = sclk;
      h2_mo = h1_mo; h1_mo = mosi;
    end
  end

  task automatic check(input bit ok, input string req, input logic [191:0] act,
                       input logic [191:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: cycle-exact comparison against the reference
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      logic [NC*DW-1:0] exp_flat;
      for (int c = 0; c < NC; c++) exp_flat[c*DW +: DW] = m_reg[c];
      check(regs_o == exp_flat, "R9 regs", regs_o, exp_flat);
      check(wr_stb_o == m_stb, "R9 strobe", 192'(wr_stb_o), 192'(m_stb));
      check(mode_o == m_reg[1][7:0], "R9 mode", 192'(mode_o), 192'(m_reg[1][7:0]));
    end
  end

  int stb_cnt [NC];
  always @(negedge clk) begin
    if (!rst_n) for (int c = 0; c < NC; c++) stb_cnt[c] = 0;
    else for (int c = 0; c < NC; c++) if (wr_stb_o[c]) stb_cnt[c]++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits rising edges; bits beyond 16 are zero
  task automatic send(input logic [15:0] w, input int nbits);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  function automatic logic [11:0] rd(input int c);
    return regs_o[c*DW +: DW];
  endfunction

  initial begin
    int s3;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    cmp_en = 1'b1;
    // R1
    check(regs_o == '0, "R1 regs", regs_o, '0);
    check(wr_stb_o == '0 && mode_o == '0, "R1 strobe/mode",
          192'({wr_stb_o, mode_o}), '0);

    send(16'h3A5C, 16);
    check(rd(3) == 12'hA5C, "R2 cmd3", 192'(rd(3)), 192'(12'hA5C));
    check(stb_cnt[3] == 1, "R4 single strobe", 192'(stb_cnt[3]), 192'(1));
    send(16'hFFFF, 16);
    check(rd(15) == 12'hFFF, "R2 cmd15", 192'(rd(15)), 192'(12'hFFF));
    send(16'h0001, 16);
    check(rd(0) == 12'h001, "R2 cmd0", 192'(rd(0)), 192'(12'h001));
    send(16'h6AAA, 16);
    check(rd(6) == 12'hAAA, "R3 alternating", 192'(rd(6)), 192'(12'hAAA));

    send(16'h1ABC, 16);
    check(mode_o == 8'hBC, "R5 mode", 192'(mode_o), 192'(8'hBC));
    check(rd(1) == 12'h0BC, "R5 upper zero", 192'(rd(1)), 192'(12'h0BC));

    s3 = stb_cnt[3];
    send(16'h3777, 15);
    check(rd(3) == 12'hA5C, "R6 short", 192'(rd(3)), 192'(12'hA5C));
    check(stb_cnt[3] == s3, "R6 no strobe", 192'(stb_cnt[3]), 192'(s3));
    send(16'h3777, 17);
    check(rd(3) == 12'hA5C, "R7 long", 192'(rd(3)), 192'(12'hA5C));
    check(stb_cnt[3] == s3, "R7 no strobe", 192'(stb_cnt[3]), 192'(s3));

    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    send(16'h3123, 16);
    check(rd(3) == 12'h123, "R8 idle edges", 192'(rd(3)), 192'(12'h123));
    check(stb_cnt[3] == s3 + 1, "R4 strobe count", 192'(stb_cnt[3]), 192'(s3 + 1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule